// File: doc/BRIEF.md
# Interval-Based Memory Traffic Throttler

This block sits between a memory controller's command scheduler and the DRAM command path. It holds power under a budget by shutting the command stream for a set number of cycles in every fixed window. Each window opens with an active stretch and closes with a stall stretch. The stall length is called the throttle delay. The throttle delay arrives on an input from outside the block, normally from a power-target estimator. The block does not take it every cycle. It samples it once per epoch, and an epoch is a much longer period made of a whole number of windows. The decision to pass or stall is made fresh on every cycle from two values: the position inside the window and the held delay.

Commands move over a valid/ready handshake, and the block sits in the middle of it. While the block stalls, it holds the downstream valid and the upstream ready low. The sender keeps its command waiting, so no command is lost. The block also reports how many cycles were stalled in the last finished epoch.

Top module: `mem_throttle_gate`

## Requirements
- R1: After reset, `allow` is 1, `active_delay` is 0 and `stall_epoch` is 0. The window and epoch positions both start at 0 on the first cycle after reset is released.
- R2: The window position p counts 0, 1, ..., WINDOW-1 and then starts again at 0, one step per cycle. `allow` is 1 when p < WINDOW - `active_delay` and 0 otherwise, so the active part of the window always comes before the stall part.
- R3: A `delay_in` value above WINDOW is held as WINDOW, which stalls the whole window. A held value of 0 never stalls.
- R4: `delay_in` is sampled only in the last cycle of an epoch (epoch position EPOCH-1). The sampled value, after clamping, appears on `active_delay` from the next cycle on. Values of `delay_in` in any other cycle have no effect on `active_delay` or `allow`.
- R5: `dn_valid` equals `up_valid` AND `allow`, and `up_ready` equals `dn_ready` AND `allow`, in the same cycle with no register between them.
- R6: Every upstream transfer (`up_valid` and `up_ready` both 1) is exactly one downstream transfer (`dn_valid` and `dn_ready` both 1). A sender that holds `up_valid` until it is accepted loses no command during a stall.
- R7: In the cycle after each epoch ends, `stall_epoch` takes the number of cycles in that epoch in which `allow` was 0. That number is (EPOCH/WINDOW) times the delay that was held during the epoch. `stall_epoch` keeps this value until the next epoch ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| delay_in | input | DLY_W | Requested stall cycles per window, sampled at the end of each epoch |
| up_valid | input | 1 | Command valid from the scheduler |
| up_ready | output | 1 | Command accepted by the throttler path |
| dn_valid | output | 1 | Command valid toward DRAM |
| dn_ready | input | 1 | DRAM command path ready |
| allow | output | 1 | 1 when traffic may pass in this cycle |
| active_delay | output | $clog2(WINDOW+1) | Clamped delay in force for this epoch |
| stall_epoch | output | $clog2(EPOCH+1) | Stalled cycles counted in the last finished epoch |

## Verification
The assertions assume that EPOCH is a whole multiple of WINDOW, so every epoch boundary is also a window boundary. Elaboration checks this, and the bench uses WINDOW=20 and EPOCH=100. The no-loss property also assumes a sender that keeps `up_valid` high until the command is accepted. The bench drives the upstream side that way: it raises or drops `up_valid` at random only after a transfer has completed. `delay_in` changes at random every cycle, so the assertion on when `active_delay` may change is exercised by values that must be ignored. In the last cycle of each epoch the bench drives a directed value instead, covering 0, WINDOW, WINDOW+1, all ones, 1 and WINDOW-1 before the random values start.

// File: rtl/thr_pkg.sv
package thr_pkg;

   // Saturate a requested delay to the window length.
   function automatic int unsigned sat_delay(input int unsigned req, input int unsigned win);
      return (req > win) ? win : req;
   endfunction

   // Width needed to hold values 0..n inclusive.
   function automatic int unsigned span_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/thr_wrap_counter.sv
module thr_wrap_counter #(
   parameter int unsigned MODULUS = 16,
   localparam int unsigned CW = (MODULUS < 2) ? 1 : $clog2(MODULUS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] count,
   output logic          at_end
);

   localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

   assign at_end = (count == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (at_end)
         count <= '0;
      else
         count <= count + 1'b1;
   end

endmodule

// File: rtl/thr_delay_hold.sv
module thr_delay_hold
   import thr_pkg::*;
#(
   parameter int unsigned WINDOW = 10000,
   parameter int unsigned DLY_W  = 16,
   localparam int unsigned TW = span_w(WINDOW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] req,
   output logic [TW-1:0]    held
);

   localparam bool_need = (DLY_W >= 32) || (((64'd1 << DLY_W) - 64'd1) > 64'(WINDOW));

   logic [TW-1:0] sat;

   generate
      if (bool_need) begin : g_clamp
         localparam logic [DLY_W-1:0] LIM_REQ = DLY_W'(WINDOW);
         localparam logic [TW-1:0]    LIM_OUT = TW'(WINDOW);
         always_comb begin
            if (req > LIM_REQ)
               sat = LIM_OUT;
            else
               sat = TW'(req);
         end
      end else begin : g_pass
         always_comb sat = TW'(req);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held <= '0;
      else if (load)
         held <= sat;
   end

endmodule

// File: rtl/thr_gate.sv
module thr_gate
   import thr_pkg::*;
#(
   parameter int unsigned WINDOW = 10000,
   parameter int unsigned EPOCH  = 1000000,
   localparam int unsigned TW = span_w(WINDOW),
   localparam int unsigned CW = (WINDOW < 2) ? 1 : $clog2(WINDOW),
   localparam int unsigned SW = span_w(EPOCH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] win_pos,
   input  logic          epoch_last,
   input  logic [TW-1:0] delay,
   input  logic          up_valid,
   output logic          up_ready,
   output logic          dn_valid,
   input  logic          dn_ready,
   output logic          allow,
   output logic [SW-1:0] stall_epoch
);

   localparam logic [TW:0] WIN_V = (TW+1)'(WINDOW);

   logic [TW:0]   open_len;
   logic [TW:0]   pos_ext;
   logic [SW-1:0] acc;
   logic [SW-1:0] acc_next;

   assign open_len = WIN_V - {1'b0, delay};
   assign pos_ext  = (TW+1)'(win_pos);
   assign allow    = (pos_ext < open_len);

   assign dn_valid = up_valid & allow;
   assign up_ready = dn_ready & allow;

   assign acc_next = acc + SW'(!allow);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc         <= '0;
         stall_epoch <= '0;
      end else if (epoch_last) begin
         acc         <= '0;
         stall_epoch <= acc_next;
      end else begin
         acc         <= acc_next;
      end
   end

endmodule

// File: rtl/mem_throttle_gate.sv
module mem_throttle_gate
   import thr_pkg::*;
#(
   parameter int unsigned WINDOW = 10000,
   parameter int unsigned EPOCH  = 1000000,
   parameter int unsigned DLY_W  = 16,
   localparam int unsigned TW = span_w(WINDOW),
   localparam int unsigned SW = span_w(EPOCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DLY_W-1:0] delay_in,
   input  logic             up_valid,
   output logic             up_ready,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic             allow,
   output logic [TW-1:0]    active_delay,
   output logic [SW-1:0]    stall_epoch
);

   localparam int unsigned CW  = (WINDOW < 2) ? 1 : $clog2(WINDOW);
   localparam int unsigned ECW = (EPOCH < 2) ? 1 : $clog2(EPOCH);

   generate
      if (WINDOW < 2) begin : g_bad_window
         $error("WINDOW must be at least 2");
      end
      if (EPOCH % WINDOW != 0) begin : g_bad_epoch
         $error("EPOCH must be a whole multiple of WINDOW");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("DLY_W must be at least 1");
      end
   endgenerate

   logic [CW-1:0]  ic;
   logic           win_last;
   logic [ECW-1:0] ec;
   logic           epoch_last;

   thr_wrap_counter #(.MODULUS(WINDOW)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .count  (ic),
      .at_end (win_last)
   );

   thr_wrap_counter #(.MODULUS(EPOCH)) u_epoch (
      .clk    (clk),
      .rst_n  (rst_n),
      .count  (ec),
      .at_end (epoch_last)
   );

   thr_delay_hold #(.WINDOW(WINDOW), .DLY_W(DLY_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (epoch_last),
      .req   (delay_in),
      .held  (active_delay)
   );

   thr_gate #(.WINDOW(WINDOW), .EPOCH(EPOCH)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_pos     (ic),
      .epoch_last  (epoch_last),
      .delay       (active_delay),
      .up_valid    (up_valid),
      .up_ready    (up_ready),
      .dn_valid    (dn_valid),
      .dn_ready    (dn_ready),
      .allow       (allow),
      .stall_epoch (stall_epoch)
   );

   logic unused_ok;
   assign unused_ok = &{1'b0, win_last, ec};

endmodule

// File: rtl/thr_gate_chk.sv
module thr_gate_chk #(
   parameter int unsigned WINDOW = 10000,
   parameter int unsigned EPOCH  = 1000000,
   parameter int unsigned TW     = 14,
   parameter int unsigned CW     = 14,
   parameter int unsigned SW     = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          allow,
   input logic          up_valid,
   input logic          up_ready,
   input logic          dn_valid,
   input logic          dn_ready,
   input logic [CW-1:0] ic,
   input logic          epoch_last,
   input logic [TW-1:0] active_delay,
   input logic [SW-1:0] stall_epoch
);

   // R2
   stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!allow && ic != CW'(WINDOW - 1)) |=> !allow);

   // R2
   win_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ic == CW'(WINDOW - 1)) |=> (ic == '0));

   // R3
   delay_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_delay <= TW'(WINDOW));

   // R4
   delay_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !epoch_last |=> $stable(active_delay));

   // R5
   down_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> (up_valid && allow));

   // R5
   up_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready |-> (dn_ready && allow));

   // R7
   stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_epoch <= SW'(EPOCH));

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !epoch_last |=> $stable(stall_epoch));

endmodule

bind mem_throttle_gate thr_gate_chk #(
   .WINDOW (WINDOW),
   .EPOCH  (EPOCH),
   .TW     (TW),
   .CW     (CW),
   .SW     (SW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .allow        (allow),
   .up_valid     (up_valid),
   .up_ready     (up_ready),
   .dn_valid     (dn_valid),
   .dn_ready     (dn_ready),
   .ic           (ic),
   .epoch_last   (epoch_last),
   .active_delay (active_delay),
   .stall_epoch  (stall_epoch)
);

// File: tb/sim_mem_throttle_gate.sv
`timescale 1ns/1ps
module sim_mem_throttle_gate;

   localparam int W  = 20;
   localparam int E  = 100;
   localparam int DW = 8;
   localparam int TW = $clog2(W + 1);
   localparam int SW = $clog2(E + 1);
   localparam int N_EPOCHS = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] delay_in = '0;
   logic          up_valid = 1'b0;
   logic          dn_ready = 1'b0;
   logic          up_ready, dn_valid, allow;
   logic [TW-1:0] active_delay;
   logic [SW-1:0] stall_epoch;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state, built from the requirements
   int ic_m = 0, ec_m = 0, t_m = 0, last_m = 0;
   int up_hs = 0, dn_hs = 0;

   always #2 clk = ~clk;

   mem_throttle_gate #(.WINDOW(W), .EPOCH(E), .DLY_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .delay_in(delay_in),
      .up_valid(up_valid), .up_ready(up_ready),
      .dn_valid(dn_valid), .dn_ready(dn_ready),
      .allow(allow), .active_delay(active_delay), .stall_epoch(stall_epoch)
   );

   function automatic int clamp_w(input int d);
      return (d > W) ? W : d;
   endfunction

   function automatic bit exp_allow(input int pos, input int t);
      return pos < (W - t);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         if (ec_m == E - 1) begin
            last_m <= (E / W) * t_m;
            t_m    <= clamp_w(int'(delay_in));
         end
         ic_m <= (ic_m == W - 1) ? 0 : ic_m + 1;
         ec_m <= (ec_m == E - 1) ? 0 : ec_m + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int plan_delay(input int k);
      case (k)
         0: return 0;
         1: return W;
         2: return W + 1;
         3: return 255;
         4: return 1;
         5: return W - 1;
         default: return $urandom_range(0, W + 10);
      endcase
   endfunction

   initial begin
      int epoch_idx;
      bit hs_prev;
      void'($urandom(32'h5EED_0042));
      epoch_idx = 0;
      hs_prev = 0;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      chk(allow == 1'b1, "R1 allow", int'(allow), 1);
      chk(active_delay == '0, "R1 active_delay", int'(active_delay), 0);
      chk(stall_epoch == '0, "R1 stall_epoch", int'(stall_epoch), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < N_EPOCHS * E; cyc++) begin
         // drive inputs for this cycle
         if (ec_m == E - 1) begin
            delay_in = DW'(plan_delay(epoch_idx));
            epoch_idx++;
         end else begin
            delay_in = DW'($urandom_range(0, 255));
         end
         if (!up_valid || hs_prev) up_valid = $urandom_range(0, 3) != 0;
         dn_ready = $urandom_range(0, 4) != 0;
         #1;
         // R2 / R3: allow follows window position and held delay
         chk(allow == exp_allow(ic_m, t_m), "R2/R3 allow", int'(allow), int'(exp_allow(ic_m, t_m)));
         // R4: held delay only updated from epoch-end samples
         chk(int'(active_delay) == t_m, "R4 active_delay", int'(active_delay), t_m);
         // R5: pass-through gating
         chk(dn_valid == (up_valid && exp_allow(ic_m, t_m)), "R5 dn_valid",
             int'(dn_valid), int'(up_valid && exp_allow(ic_m, t_m)));
         chk(up_ready == (dn_ready && exp_allow(ic_m, t_m)), "R5 up_ready",
             int'(up_ready), int'(dn_ready && exp_allow(ic_m, t_m)));
         // R7: stall count of last finished epoch
         chk(int'(stall_epoch) == last_m, "R7 stall_epoch", int'(stall_epoch), last_m);
         hs_prev = up_valid && up_ready;
         if (hs_prev) up_hs++;
         if (dn_valid && dn_ready) dn_hs++;
         @(negedge clk);
      end
      // R6: every accepted command reached the DRAM side
      chk(up_hs == dn_hs, "R6 transfers", dn_hs, up_hs);
      chk(up_hs > 0, "R6 traffic seen", up_hs, 1);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule